// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block decides, for each 32-bit address issued on the CPU side, whether the access belongs to the PCI bus. The upper part of the address map, from 0xF0000000 upward, is cut into 32 chunks of 8 MiB each. A chunk is forwarded when software has set its bit in an enable mask and a two-bit gate field in a control register holds the enabling code. The block reports a forward flag together with the number of the chunk that was hit.

A second, independent decode classifies addresses mastered by PCI devices into system RAM, PCI memory, the CPU local region, or nothing. Both registers are written through a simple one-cycle write strobe with a register select. Their current values are always visible on read-back outputs. Both decodes are purely combinational from the registers and the address inputs.

Top module: `outbound_window_decoder`

## Requirements
- R1: A CPU address A at or above 0xF0000000 lies in chunk i = (A - 0xF0000000) / 0x800000 (i in 0..31, i.e. A[27:23]); on a forward hit `win_idx` equals i.
- R2: A write with `reg_sel`=0 stores `reg_wdata & 0x7FFFFFFE` into the enable mask; `mask_rd` shows it, so bits 0 and 31 always read zero and chunks 0 and 31 never forward.
- R3: A write with `reg_sel`=1 stores all 32 bits of `reg_wdata` into the control register, shown on `ctrl_rd`; without a write both registers hold their value.
- R4: `fwd` is 1 exactly when control bits [8:7] equal 2'b01, the address is at or above 0xF0000000, and the mask bit of its chunk is set; any other gate code blocks every chunk.
- R5: A register write changes the decode outputs from the clock edge that performs it, with no further delay.
- R6: `win_idx` is 0 whenever `fwd` is 0.
- R7: The bus-master decode gives `bm_class`=1 (system RAM) for addresses 0x00000000 to 0xF07FFFFF.
- R8: The bus-master decode gives `bm_class`=2 (PCI memory) for addresses 0xF0800000 to 0xFF7FFFFF (30 chunks).
- R9: The bus-master decode gives `bm_class`=3 (CPU local) for 0xFFF00000 to 0xFFFFFFFE, a span of 0xFFFFF bytes, and 0 (no hit) for 0xFF800000 to 0xFFEFFFFF and for 0xFFFFFFFF.
- R10: After reset both registers are zero and nothing is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the enable mask, 1 the control register |
| reg_wdata | input | 32 | Write data |
| mask_rd | output | 32 | Current enable mask |
| ctrl_rd | output | 32 | Current control register |
| cpu_addr | input | 32 | CPU-side address to decode |
| fwd | output | 1 | Address is forwarded to PCI |
| win_idx | output | 5 | Chunk hit, valid when `fwd` is 1 |
| bm_addr | input | 32 | Bus-master address to classify |
| bm_class | output | 2 | 0 none, 1 system RAM, 2 PCI memory, 3 CPU local |

## Verification
The CPU decode is swept across the first and last byte of every chunk with a full mask, then with sparse and alternating masks, which separates an off-by-one in the chunk field from a mask indexing fault. Every gate code from 0 to 3 is tried, together with set bits outside the gate field, so that a decode testing a single bit can be told apart from an exact compare. The bus-master decode is driven at both sides of every region boundary, including the last CPU-local byte and the all-ones address. A long stretch of pseudo-random addresses and register writes then mixes all of these against the bench model.

// File: rtl/outbound_window_decoder.sv
module outbound_window_decoder #(
  parameter int AW        = 32,
  parameter int NWIN_LOG  = 5,
  parameter int CHUNK_LOG = 23,
  parameter int GATE_LSB  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_sel,
  input  logic [AW-1:0]       reg_wdata,
  output logic [AW-1:0]       mask_rd,
  output logic [AW-1:0]       ctrl_rd,
  input  logic [AW-1:0]       cpu_addr,
  output logic                fwd,
  output logic [NWIN_LOG-1:0] win_idx,
  input  logic [AW-1:0]       bm_addr,
  output logic [1:0]          bm_class
);
  localparam int NWIN = 1 << NWIN_LOG;
  localparam int TOP_LSB = CHUNK_LOG + NWIN_LOG;
  localparam logic [AW-1:0] ALLOWED = {1'b0, {(NWIN-2){1'b1}}, 1'b0};
  localparam logic [AW-1:0] WIN_BASE = 32'hF000_0000;
  localparam logic [AW-1:0] PCI_LO = WIN_BASE + (32'd1 << CHUNK_LOG);
  localparam logic [AW-1:0] PCI_HI = PCI_LO + ((NWIN - 2) << CHUNK_LOG);
  localparam logic [AW-1:0] LOC_LO = 32'hFFF0_0000;
  localparam logic [AW-1:0] LOC_HI = LOC_LO + 32'h000F_FFFF;

  logic [AW-1:0] mask_q, ctrl_q;
  logic [NWIN_LOG-1:0] chunk;
  logic in_top, gate_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (reg_wr) begin
      if (reg_sel) ctrl_q <= reg_wdata;
      else         mask_q <= reg_wdata & ALLOWED;
    end
  end

  assign mask_rd = mask_q;
  assign ctrl_rd = ctrl_q;

  assign chunk   = cpu_addr[TOP_LSB-1:CHUNK_LOG];
  assign in_top  = &cpu_addr[AW-1:TOP_LSB];
  assign gate_on = ctrl_q[GATE_LSB+1:GATE_LSB] == 2'b01;
  assign fwd     = gate_on & in_top & mask_q[chunk];
  assign win_idx = fwd ? chunk : '0;

  always_comb begin
    if (bm_addr < PCI_LO)                          bm_class = 2'd1;
    else if (bm_addr < PCI_HI)                     bm_class = 2'd2;
    else if (bm_addr >= LOC_LO && bm_addr < LOC_HI) bm_class = 2'd3;
    else                                           bm_class = 2'd0;
  end

  // R2
  mask_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> (!mask_rd[0] && !mask_rd[AW-1] &&
                              mask_rd[AW-2:1] == $past(reg_wdata[AW-2:1])));
  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(ctrl_rd) && $stable(mask_rd)));
  // R4
  fwd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (ctrl_rd[GATE_LSB+1:GATE_LSB] == 2'b01 && cpu_addr >= WIN_BASE));
  // R6
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd |-> win_idx == '0);
  // R2
  idx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (win_idx != '0 && win_idx != {NWIN_LOG{1'b1}}));
  // R9
  bm_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&bm_addr) |-> bm_class == 2'd0);
endmodule

// File: tb/sim_outbound_window_decoder.sv
module sim_outbound_window_decoder;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, cpu_addr = 0, bm_addr = 0;
  logic [31:0] mask_rd, ctrl_rd;
  logic fwd;
  logic [4:0] win_idx;
  logic [1:0] bm_class;

  int vecs = 0, errs = 0;
  longint m_mask = 0, m_ctrl = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  outbound_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mask_rd(mask_rd), .ctrl_rd(ctrl_rd),
    .cpu_addr(cpu_addr), .fwd(fwd), .win_idx(win_idx),
    .bm_addr(bm_addr), .bm_class(bm_class));

  task automatic compare();
    longint a = longint'(cpu_addr), b = longint'(bm_addr);
    int e_fwd = 0, e_idx = 0, e_cls = 0;
    if (((m_ctrl >> 7) & 3) == 1 && a >= 64'hF000_0000) begin
      int i = int'((a - 64'hF000_0000) / 64'h80_0000);
      if ((m_mask >> i) & 1) begin e_fwd = 1; e_idx = i; end
    end
    if (b < 64'hF080_0000) e_cls = 1;
    else if (b < 64'hF080_0000 + 30 * 64'h80_0000) e_cls = 2;
    else if (b >= 64'hFFF0_0000 && b < 64'hFFF0_0000 + 64'hF_FFFF) e_cls = 3;
    vecs++;
    if (longint'(mask_rd) != m_mask) begin errs++;
      $display("FAIL R2/R10 mask_rd actual %h expected %h", mask_rd, m_mask); end
    if (longint'(ctrl_rd) != m_ctrl) begin errs++;
      $display("FAIL R3/R10 ctrl_rd actual %h expected %h", ctrl_rd, m_ctrl); end
    if (int'(fwd) != e_fwd) begin errs++;
      $display("FAIL R4/R5 fwd @%h actual %0d expected %0d", cpu_addr, fwd, e_fwd); end
    if (int'(win_idx) != e_idx) begin errs++;
      $display("FAIL R1/R6 win_idx @%h actual %0d expected %0d", cpu_addr, win_idx, e_idx); end
    if (int'(bm_class) != e_cls) begin errs++;
      $display("FAIL R7/R8/R9 bm_class @%h actual %0d expected %0d", bm_addr, bm_class, e_cls); end
  endtask

  task automatic step(input bit wr, input bit sel, input logic [31:0] wd,
                      input logic [31:0] ca, input logic [31:0] ba);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; cpu_addr = ca; bm_addr = ba;
    #1 compare();
    if (wr) begin
      if (sel) m_ctrl = longint'(wd);
      else m_mask = longint'(wd) & 64'h7FFF_FFFE;
    end
  endtask

  task automatic sweep_chunks();
    for (int i = 0; i < 32; i++) begin
      step(0, 0, 0, 32'hF000_0000 + i * 32'h80_0000, 32'h0);
      step(0, 0, 0, 32'hF000_0000 + i * 32'h80_0000 + 32'h7F_FFFF, 32'h0);
    end
  endtask

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    // R10: state during and after reset
    step(0, 0, 0, 32'hF080_0000, 32'h0);
    @(negedge clk) rst_n = 1;
    step(0, 0, 0, 32'hF080_0000, 32'hF080_0000);
    // R2: edge bits stripped; R5: takes effect next cycle
    step(1, 0, 32'hFFFF_FFFF, 32'hF080_0000, 32'hFF7F_FFFF);
    step(1, 1, 32'h0000_0080, 32'hF080_0000, 32'hFF80_0000);
    step(0, 0, 0, 32'hF080_0000, 32'hFFEF_FFFF);
    // R1/R4: every chunk, both edges
    sweep_chunks();
    // R4: other gate codes, and stray bits around the gate field
    step(1, 1, 32'h0000_0180, 32'hF100_0000, 32'hFFF0_0000);
    step(0, 0, 0, 32'hF100_0000, 32'hFFFF_FFFE);
    step(1, 1, 32'h0000_0100, 32'hF100_0000, 32'hFFFF_FFFF);
    step(1, 1, 32'h0000_0000, 32'hF100_0000, 32'hF07F_FFFF);
    step(1, 1, 32'hFFFF_FE7F, 32'hF100_0000, 32'h0000_0000);
    sweep_chunks();
    step(1, 1, 32'h0000_0080, 32'hEFFF_FFFF, 32'h8000_0000);
    // sparse and alternating masks
    step(1, 0, 32'h0000_0AAA, 32'h0, 32'hF080_0000);
    sweep_chunks();
    step(1, 0, 32'h8000_0001, 32'hF000_0000, 32'hFFF0_0000);
    step(0, 0, 0, 32'hFF80_0000, 32'hFFFF_FFFE);
    step(1, 0, 32'h5555_5555, 32'h0, 32'hFFFF_FFFF);
    sweep_chunks();
    // R8/R9: boundary walk of the bus-master map
    foreach (lfsr[k]) begin
      step(0, 0, 0, 32'h0, 32'hFF7F_FFF0 + k);
      step(0, 0, 0, 32'h0, 32'hFFEF_FFF0 + k);
      step(0, 0, 0, 32'h0, 32'hFFFF_FFE0 + k);
    end
    // mixed pseudo-random traffic
    for (int n = 0; n < 3000; n++) begin
      bit w;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = (lfsr[7:4] == 4'h0);
      step(w, lfsr[9], (lfsr[9] && lfsr[3]) ? 32'h80 : {lfsr[15:0], lfsr[31:16]},
           {4'hF, lfsr[27:0]} ^ {lfsr[2], 31'h0}, ~lfsr);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual running expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule